// File: doc/BRIEF.md
# SD Four-Lane Data Block Receiver

This block captures a data block arriving on the four SD data lines while a separate engine generates the SD clock. The receiver watches DAT0 for the start bit, locks onto the next rising edge of the SD clock, and then takes one four-bit sample per SD clock period. The sampling instant is one full divider period after each rising edge, counted in system clocks. The samples are packed, most significant nibble first, into 32-bit words, and each word is handed to an output FIFO.

Software programs the divider ratio (`clkDiv`) and the number of nibbles per block minus one (`nibbleCount`), then raises `rxEnable`. The SD clock and data lines are treated as asynchronous. Both pass through the same two-flop synchronizer, so their relative timing is preserved. If the FIFO is full at the moment a sample would complete a word, sampling stalls and a sticky overrun flag is raised.

Top module: `sdNibbleRx`

## Requirements
- R1: After reset, `wordValid` and `overrun` are 0. While `rxEnable` is 0, no word is produced, whatever happens on `sdClk` and `sdDat`.
- R2: A block starts only once DAT0 (`sdDat[0]`) is seen low. While DAT0 stays high, SD clock edges cause no sampling.
- R3: Once the start bit is seen, the first rising `sdClk` edge sets the alignment. Nibble k (k counting from 1) is sampled clkDiv system clocks times k after that edge. The word that the 8th nibble completes appears on `wordValid` 3 system clocks after the clock edge at which the raw `sdClk` first reads high in that nibble's period.
- R4: Each block takes exactly `nibbleCount`+1 samples, with `nibbleCount` reloaded at every block start. The receiver then returns to waiting for a start bit.
- R5: Nibbles shift in most significant first: the first nibble of a word lands in bits 31:28 and the 8th in bits 3:0. Each group of 8 samples produces one single-cycle `wordValid` pulse.
- R6: A partial word left at the end of a block is kept while `rxEnable` stays high. The next block's nibbles continue filling it.
- R7: A `clkDiv` value below 2 acts as 2.
- R8: If `fifoFull` is high when a sample would complete a word, that sample is held off and `overrun` goes to 1. No word is pushed while `fifoFull` is high. Sampling resumes once `fifoFull` falls. `overrun` stays 1 until `rxEnable` goes low or reset.
- R9: Dropping `rxEnable` aborts a block in progress, discards any partial word and clears `overrun`. A block received after re-enabling starts a fresh word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxEnable | input | 1 | Arms the receiver; low aborts and clears it |
| clkDiv | input | 8 | System clocks per SD clock period |
| nibbleCount | input | 12 | Nibbles per block minus one |
| sdClk | input | 1 | SD clock as driven by the clock engine (asynchronous) |
| sdDat | input | 4 | SD data lines, DAT0 in bit 0 (asynchronous) |
| fifoFull | input | 1 | Output FIFO cannot accept a word |
| wordValid | output | 1 | One-cycle push strobe for `wordData` |
| wordData | output | 32 | Packed word, first nibble in bits 31:28 |
| overrun | output | 1 | Sticky flag: a sample was delayed by a full FIFO |

## Verification
The sample that completes a word can fall in the same cycle as a full FIFO, so the receiver must choose between pushing and stalling. The bench provokes this by holding `fifoFull` high across a whole 16-nibble block. It then judges the outcome by three observations:
- no word appears while the FIFO is full;
- `overrun` is set and stays set;
- both words are delivered once `fifoFull` is released.

The second collision is an abort arriving while a partial word sits in the packer. This is judged by the first word after re-enabling, which must contain only fresh nibbles.

// File: rtl/sdNibbleRxPkg.sv
package sdNibbleRxPkg;

  typedef enum logic [1:0] {
    S_WAIT_START,
    S_WAIT_EDGE,
    S_RUN
  } rxState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic sample;   // capture one nibble this cycle
    logic clear;    // drop packer contents
  } rxStrobe_t;

endpackage

// File: rtl/sdRxSync.sv
module sdRxSync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stageQ [STAGES];

  // Reset to all ones: lines idle high, and no false clock edge appears after reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stageQ[i] <= '1;
    end else begin
      stageQ[0] <= din;
      for (int i = 1; i < STAGES; i++) stageQ[i] <= stageQ[i-1];
    end
  end

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/sdRxDatapath.sv
module sdRxDatapath
  import sdNibbleRxPkg::*;
#(
  parameter int LANES  = 4,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncClk,
  input  logic [LANES-1:0]  syncDat,
  input  rxStrobe_t         strobe,
  output logic              datLine0,
  output logic              clkRise,
  output logic              wordLast,
  output logic              wordValid,
  output logic [WORD_W-1:0] wordData
);

  localparam int NIB_PER_WORD = WORD_W / LANES;
  localparam int PHASE_W = (NIB_PER_WORD > 1) ? $clog2(NIB_PER_WORD) : 1;
  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(NIB_PER_WORD - 1);

  logic                clkPrev;
  logic [WORD_W-1:0]   shiftReg;
  logic [PHASE_W-1:0]  phase;
  logic [WORD_W-1:0]   nextWord;

  assign datLine0 = syncDat[0];
  assign clkRise  = syncClk & ~clkPrev;
  assign wordLast = (phase == LAST_PHASE);
  assign nextWord = {shiftReg[WORD_W-LANES-1:0], syncDat};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clkPrev <= 1'b1;
    else       clkPrev <= syncClk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      phase     <= '0;
      wordValid <= 1'b0;
      wordData  <= '0;
    end else if (strobe.clear) begin
      shiftReg  <= '0;
      phase     <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= 1'b0;
      if (strobe.sample) begin
        shiftReg <= nextWord;
        if (wordLast) begin
          phase     <= '0;
          wordData  <= nextWord;
          wordValid <= 1'b1;
        end else begin
          phase <= phase + PHASE_W'(1);
        end
      end
    end
  end

  // A push is always the result of a sample in the previous cycle
  assert_push_follows_sample_R5: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> $past(strobe.sample));

endmodule

// File: rtl/sdRxControl.sv
module sdRxControl
  import sdNibbleRxPkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxEnable,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic [CNT_W-1:0] nibbleCount,
  input  logic             fifoFull,
  input  logic             datLine0,
  input  logic             clkRise,
  input  logic             wordLast,
  output rxStrobe_t        strobe,
  output logic             overrun
);

  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

  rxState_t         state;
  logic [DIV_W-1:0] waitCnt;
  logic [DIV_W-1:0] effDiv;
  logic [DIV_W-1:0] reload;
  logic [CNT_W-1:0] remaining;
  logic             sampleDue;
  logic             stallNow;

  assign effDiv    = (clkDiv < MIN_DIV) ? MIN_DIV : clkDiv;
  assign reload    = effDiv - DIV_W'(1);
  assign sampleDue = rxEnable && (state == S_RUN) && (waitCnt == '0);
  assign stallNow  = sampleDue && wordLast && fifoFull;

  always_comb begin
    strobe.sample = sampleDue && !stallNow;
    strobe.clear  = !rxEnable;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_WAIT_START;
      waitCnt   <= '0;
      remaining <= '0;
      overrun   <= 1'b0;
    end else if (!rxEnable) begin
      state     <= S_WAIT_START;
      waitCnt   <= '0;
      remaining <= '0;
      overrun   <= 1'b0;
    end else begin
      case (state)
        S_WAIT_START: begin
          remaining <= nibbleCount;
          if (!datLine0) state <= S_WAIT_EDGE;
        end
        S_WAIT_EDGE: begin
          if (clkRise) begin
            waitCnt <= reload;
            state   <= S_RUN;
          end
        end
        S_RUN: begin
          if (waitCnt != '0) begin
            waitCnt <= waitCnt - DIV_W'(1);
          end else if (stallNow) begin
            overrun <= 1'b1;
          end else begin
            waitCnt <= reload;
            if (remaining == '0) state <= S_WAIT_START;
            else                 remaining <= remaining - CNT_W'(1);
          end
        end
        default: state <= S_WAIT_START;
      endcase
    end
  end

  // Samples are at least two system clocks apart
  assert_sample_gap_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sample |=> !strobe.sample);

  // Overrun holds while enabled
  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && rxEnable) |=> overrun);

  // Disable leaves the receiver idle in the next cycle
  assert_disable_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> !strobe.sample);

  // Waiting for a start bit never leads straight into a sample
  assert_start_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT_START) |=> !strobe.sample);

endmodule

// File: rtl/sdNibbleRx.sv
module sdNibbleRx
  import sdNibbleRxPkg::*;
#(
  parameter int LANES  = 4,
  parameter int WORD_W = 32,
  parameter int DIV_W  = 8,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic [CNT_W-1:0]  nibbleCount,
  input  logic              sdClk,
  input  logic [LANES-1:0]  sdDat,
  input  logic              fifoFull,
  output logic              wordValid,
  output logic [WORD_W-1:0] wordData,
  output logic              overrun
);

  localparam int BUS_W = LANES + 1;

  logic [BUS_W-1:0] syncBus;
  rxStrobe_t        strobe;
  logic             datLine0;
  logic             clkRise;
  logic             wordLast;

  sdRxSync #(.WIDTH(BUS_W), .STAGES(2)) sync_i (
    .clk  (clk),
    .rstN (rstN),
    .din  ({sdClk, sdDat}),
    .dout (syncBus)
  );

  sdRxDatapath #(.LANES(LANES), .WORD_W(WORD_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .syncClk   (syncBus[LANES]),
    .syncDat   (syncBus[LANES-1:0]),
    .strobe    (strobe),
    .datLine0  (datLine0),
    .clkRise   (clkRise),
    .wordLast  (wordLast),
    .wordValid (wordValid),
    .wordData  (wordData)
  );

  sdRxControl #(.DIV_W(DIV_W), .CNT_W(CNT_W)) ctl_i (
    .clk         (clk),
    .rstN        (rstN),
    .rxEnable    (rxEnable),
    .clkDiv      (clkDiv),
    .nibbleCount (nibbleCount),
    .fifoFull    (fifoFull),
    .datLine0    (datLine0),
    .clkRise     (clkRise),
    .wordLast    (wordLast),
    .strobe      (strobe),
    .overrun     (overrun)
  );

  // No word is pushed into a FIFO that was full at the decision edge
  assert_no_push_full_R8: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> $past(!fifoFull));

endmodule

// File: tb/sdNibbleRx_tb_top.sv
`timescale 1ns/1ps
module sdNibbleRx_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxEnable = 1'b0;
  logic [7:0]  clkDiv = 8'd4;
  logic [11:0] nibbleCount = 12'd7;
  logic        sdClk = 1'b0;
  logic [3:0]  sdDat = 4'hF;
  logic        fifoFull = 1'b0;
  logic        wordValid;
  logic [31:0] wordData;
  logic        overrun;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lastRise = 0;
  int riseAt [64];
  logic [31:0] got [64];
  int gotCyc [64];
  int gotN = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sdNibbleRx dut_i (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .clkDiv(clkDiv),
    .nibbleCount(nibbleCount), .sdClk(sdClk), .sdDat(sdDat),
    .fifoFull(fifoFull), .wordValid(wordValid), .wordData(wordData),
    .overrun(overrun)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (wordValid && gotN < 64) begin
      got[gotN]    = wordData;
      gotCyc[gotN] = cyc;
      gotN++;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // One SD clock period: the data changes on the falling edge
  task automatic sdPeriod(input logic [3:0] nib, input int div);
    sdClk = 1'b0;
    sdDat = nib;
    repeat (div - div/2) @(negedge clk);
    sdClk = 1'b1;
    lastRise = cyc;
    repeat (div/2) @(negedge clk);
  endtask

  task automatic sendBlock(input logic [63:0] nibs, input int n, input int div);
    repeat (2) sdPeriod(4'hF, div);
    sdPeriod(4'h0, div);
    for (int k = 0; k < n; k++) begin
      sdPeriod(nibs[63-4*k -: 4], div);
      riseAt[k] = lastRise;
    end
    repeat (3) sdPeriod(4'hF, div);
  endtask

  task automatic testReset();
    check("R1 wordValid after reset", 32'(wordValid), 32'd0);
    check("R1 overrun after reset", 32'(overrun), 32'd0);
  endtask

  task automatic testDisabled();
    int n0 = gotN;
    rxEnable = 1'b0;
    nibbleCount = 12'd7;
    sendBlock(64'hA5C396E1_00000000, 8, 4);
    check("R1 no word while disabled", 32'(gotN - n0), 32'd0);
  endtask

  task automatic testNoStart();
    int n0 = gotN;
    rxEnable = 1'b1;
    clkDiv = 8'd4;
    repeat (10) sdPeriod(4'hF, 4);
    check("R2 no word without start bit", 32'(gotN - n0), 32'd0);
  endtask

  task automatic testBasic();
    int n0 = gotN;
    clkDiv = 8'd4;
    nibbleCount = 12'd7;
    sendBlock(64'hA5C396E1_00000000, 8, 4);
    check("R5 word count basic", 32'(gotN - n0), 32'd1);
    check("R5 packed word basic", got[n0], 32'hA5C396E1);
    check("R3 word timing div4", 32'(gotCyc[n0]), 32'(riseAt[7] + 3));
  endtask

  task automatic testTwoWords();
    int n0 = gotN;
    clkDiv = 8'd5;
    nibbleCount = 12'd15;
    sendBlock(64'h01234567_89ABCDEF, 16, 5);
    check("R4 word count for 16 nibbles", 32'(gotN - n0), 32'd2);
    check("R5 first word", got[n0], 32'h01234567);
    check("R5 second word", got[n0+1], 32'h89ABCDEF);
    check("R3 word timing div5", 32'(gotCyc[n0]), 32'(riseAt[7] + 3));
  endtask

  task automatic testCarry();
    int n0 = gotN;
    clkDiv = 8'd4;
    nibbleCount = 12'd3;
    sendBlock(64'h12350000_00000000, 4, 4);
    check("R6 no word after half", 32'(gotN - n0), 32'd0);
    sendBlock(64'h789B0000_00000000, 4, 4);
    check("R6 one word after two halves", 32'(gotN - n0), 32'd1);
    check("R6 carried word", got[n0], 32'h1235789B);
  endtask

  task automatic testMinDiv();
    int n0 = gotN;
    clkDiv = 8'd1;
    nibbleCount = 12'd7;
    sendBlock(64'h3C3C5A5B_00000000, 8, 2);
    check("R7 word at divider 1", got[n0], 32'h3C3C5A5B);
    check("R7 word timing divider 1", 32'(gotCyc[n0]), 32'(riseAt[7] + 3));
  endtask

  task automatic testOverrun();
    int n0 = gotN;
    clkDiv = 8'd4;
    nibbleCount = 12'd15;
    fifoFull = 1'b1;
    sendBlock(64'hFEDCBA98_76543211, 16, 4);
    check("R8 no push while full", 32'(gotN - n0), 32'd0);
    check("R8 overrun raised", 32'(overrun), 32'd1);
    fifoFull = 1'b0;
    repeat (30) sdPeriod(4'hF, 4);
    check("R8 both words after release", 32'(gotN - n0), 32'd2);
    check("R8 overrun sticky", 32'(overrun), 32'd1);
    rxEnable = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 disable clears overrun", 32'(overrun), 32'd0);
    rxEnable = 1'b1;
  endtask

  task automatic testAbort();
    int n0;
    clkDiv = 8'd4;
    nibbleCount = 12'd15;
    sendBlock(64'h9ABCD000_00000000, 5, 4);
    rxEnable = 1'b0;
    repeat (4) @(negedge clk);
    rxEnable = 1'b1;
    n0 = gotN;
    nibbleCount = 12'd7;
    sendBlock(64'h2468ACE1_00000000, 8, 4);
    check("R9 one word after abort", 32'(gotN - n0), 32'd1);
    check("R9 fresh word after abort", got[n0], 32'h2468ACE1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDisabled();
    testNoStart();
    testBasic();
    testTwoWords();
    testCarry();
    testMinDiv();
    testOverrun();
    testAbort();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule